// File: doc/BRIEF.md
# Address Mark Sync and Read Sequencer

This block takes a recovered serial stream from a disk read channel. Each sample arrives with a one-cycle strobe, at twice the data rate, so clock bits and data bits alternate. The block looks for an address mark in two stages. First it slides a 16-sample window over the stream until the window equals a fixed sync pattern. It then compares the next 16 samples against the mark pattern whose data byte is the mark type requested on `mark_type`. A wrong second half sends the search back to its start.

Once a full mark is found, the block takes only every second sample (the data bit) and assembles bytes, most significant bit first. A CRC register is loaded from the mark byte and is advanced only on these data bits. After the programmed number of field bytes plus two CRC bytes, the block reports whether the remainder is zero. It holds that status for a fixed window and returns to the search.

Top module: `amark_seq`

## Requirements
- R1: After reset, `mark_found`, `byte_vld`, `crc_vld` and `crc_good` are all low.
- R2: Samples are taken only on cycles with `smp_stb` high. The search fires when the last 16 samples are the sync clock byte 0xC7 interleaved with the sync data byte 0xF5, clock bit first and MSB first (c7,d7,c6,d6,...,c0,d0). The next 16 samples are then compared against the clock byte 0xC7 interleaved with `mark_type`. On a match, `mark_found` pulses for one cycle.
- R3: If the second half does not match, no `mark_found` and no bytes are produced, and the search restarts. A following correct frame is found normally.
- R4: After a mark, the first sample of each pair (the clock position) is ignored and only the second (data) sample is shifted in. Bytes are delivered MSB first on `byte_data`, with a one-cycle `byte_vld` pulse.
- R5: A field delivers exactly `fld_len` + 2 bytes, including the two CRC bytes, and then the block returns to the search. `fld_len` = 0 gives only the two CRC bytes.
- R6: The CRC uses x^16+x^12+x^5+1, MSB first, with the register preset to 0xFFFF. It covers the mark data byte, the field bytes and the two CRC bytes (high byte first). A zero remainder gives `crc_good` = 1.
- R7: A corrupted field or CRC byte gives `crc_good` = 0.
- R8: `crc_vld` rises in the cycle after the last `byte_vld` and stays high for exactly HOLD_CYC cycles. `crc_good` is stable while `crc_vld` is high.
- R9: While `en` is low, the block is in the search state with all outputs low and strobes are ignored. A field interrupted by `en` produces no further bytes and no CRC status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces the search state |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample |
| smp_bit | input | 1 | Serial sample (clock or data position) |
| mark_type | input | 8 | Data byte of the requested mark |
| fld_len | input | FLD_W | Field length in bytes, excluding CRC |
| mark_found | output | 1 | One-cycle pulse on a complete mark match |
| byte_vld | output | 1 | One-cycle pulse with an assembled byte |
| byte_data | output | 8 | Assembled byte |
| crc_vld | output | 1 | CRC status window, HOLD_CYC cycles |
| crc_good | output | 1 | Zero remainder at the end of the field |

## Verification
A slip in the clock/data phase after the mark shows up on the very first byte: it carries clock bits instead of data bits. A wrong sample count or a CRC that advances on clock samples usually shows up one field later, as a wrong byte count or a wrong `crc_good`. A stale search state shows up as a missing or extra `mark_found` pulse within the next 32 strobes. A miscounted hold timer changes the width of the `crc_vld` window, which is measured exactly.

// File: rtl/amark_pkg.sv
package amark_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_MARK = 2'd1,
    ST_DATA = 2'd2
  } amk_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  // clock bit first, MSB first: c7,d7,...,c0,d0 (oldest sample in bit 15)
  function automatic logic [15:0] interleave(input logic [7:0] cb, input logic [7:0] db);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i+1] = cb[i];
      r[2*i]   = db[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) r = crc_step(r, b[k]);
    return r;
  endfunction

endpackage

// File: rtl/amark_window.sv
module amark_window #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  input  logic [W-1:0] pat_a,
  input  logic [W-1:0] pat_b,
  output logic         hit_a,
  output logic         hit_b
);
  logic [W-1:0] win_q, win_d, win_shift;

  assign win_shift = {win_q[W-2:0], bit_in};
  assign hit_a     = (win_shift == pat_a);
  assign hit_b     = (win_shift == pat_b);

  always_comb begin
    win_d = win_q;
    if (clr)        win_d = '0;
    else if (shift) win_d = win_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/amark_crc16.sv
module amark_crc16
  import amark_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  seed_byte,
  input  logic        step,
  input  logic        bit_in,
  output logic [15:0] crc_q
);
  logic [15:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (load)      crc_d = crc_byte(CRC_INIT, seed_byte);
    else if (step) crc_d = crc_step(crc_q, bit_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/amark_hold.sv
module amark_hold #(
  parameter int HOLD_CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic good_in,
  output logic vld,
  output logic good
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          good_q, good_d;

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    if (clr) begin
      cnt_d  = '0;
      good_d = 1'b0;
    end else if (load) begin
      cnt_d  = CW'(HOLD_CYC);
      good_d = good_in;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) good_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  assign vld  = (cnt_q != '0);
  assign good = good_q;
endmodule

// File: rtl/amark_seq.sv
module amark_seq
  import amark_pkg::*;
#(
  parameter int         FLD_W    = 8,
  parameter int         HOLD_CYC = 8000,
  parameter logic [7:0] SYNC_CLK = 8'hC7,
  parameter logic [7:0] SYNC_DAT = 8'hF5,
  parameter logic [7:0] MARK_CLK = 8'hC7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smp_stb,
  input  logic             smp_bit,
  input  logic [7:0]       mark_type,
  input  logic [FLD_W-1:0] fld_len,
  output logic             mark_found,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic             crc_vld,
  output logic             crc_good
);
  localparam int HALF = 16;
  localparam int SCW  = $clog2(HALF);
  localparam int BCW  = FLD_W + 1;

  amk_state_e     state_q, state_d;
  logic [SCW-1:0] scnt_q, scnt_d;
  logic           phase_q, phase_d;
  logic [2:0]     bitc_q, bitc_d;
  logic [BCW-1:0] bytec_q, bytec_d;
  logic [7:0]     sr_q, sr_d;
  logic           found_q, found_d;
  logic           bvld_q, bvld_d;
  logic [7:0]     bdat_q, bdat_d;
  logic           fin_q, fin_d;

  logic           hit_a, hit_b;
  logic           crc_load, crc_step_en;
  logic [15:0]    crc_q;
  logic [BCW-1:0] last_byte;

  assign last_byte = {1'b0, fld_len} + BCW'(1);

  amark_window #(.W(HALF)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!en),
    .shift  (en && smp_stb),
    .bit_in (smp_bit),
    .pat_a  (interleave(SYNC_CLK, SYNC_DAT)),
    .pat_b  (interleave(MARK_CLK, mark_type)),
    .hit_a  (hit_a),
    .hit_b  (hit_b)
  );

  amark_crc16 u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (crc_load),
    .seed_byte (mark_type),
    .step      (crc_step_en),
    .bit_in    (smp_bit),
    .crc_q     (crc_q)
  );

  amark_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!en),
    .load    (fin_q),
    .good_in (crc_q == 16'h0000),
    .vld     (crc_vld),
    .good    (crc_good)
  );

  always_comb begin
    state_d     = state_q;
    scnt_d      = scnt_q;
    phase_d     = phase_q;
    bitc_d      = bitc_q;
    bytec_d     = bytec_q;
    sr_d        = sr_q;
    bdat_d      = bdat_q;
    found_d     = 1'b0;
    bvld_d      = 1'b0;
    fin_d       = 1'b0;
    crc_load    = 1'b0;
    crc_step_en = 1'b0;
    if (!en) begin
      state_d = ST_HUNT;
      scnt_d  = '0;
      phase_d = 1'b0;
      bitc_d  = '0;
      bytec_d = '0;
    end else if (smp_stb) begin
      unique case (state_q)
        ST_HUNT: begin
          if (hit_a) begin
            state_d = ST_MARK;
            scnt_d  = '0;
          end
        end
        ST_MARK: begin
          scnt_d = scnt_q + 1'b1;
          if (scnt_q == SCW'(HALF - 1)) begin
            if (hit_b) begin
              state_d  = ST_DATA;
              found_d  = 1'b1;
              crc_load = 1'b1;
              phase_d  = 1'b0;
              bitc_d   = '0;
              bytec_d  = '0;
            end else begin
              state_d = ST_HUNT;
            end
          end
        end
        ST_DATA: begin
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d     = 1'b0;
            crc_step_en = 1'b1;
            sr_d        = {sr_q[6:0], smp_bit};
            bitc_d      = bitc_q + 1'b1;
            if (bitc_q == 3'd7) begin
              bvld_d  = 1'b1;
              bdat_d  = {sr_q[6:0], smp_bit};
              bytec_d = bytec_q + 1'b1;
              if (bytec_q == last_byte) begin
                state_d = ST_HUNT;
                fin_d   = 1'b1;
              end
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      scnt_q  <= '0;
      phase_q <= 1'b0;
      bitc_q  <= '0;
      bytec_q <= '0;
      sr_q    <= '0;
      found_q <= 1'b0;
      bvld_q  <= 1'b0;
      bdat_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      phase_q <= phase_d;
      bitc_q  <= bitc_d;
      bytec_q <= bytec_d;
      sr_q    <= sr_d;
      found_q <= found_d;
      bvld_q  <= bvld_d;
      bdat_q  <= bdat_d;
      fin_q   <= fin_d;
    end
  end

  assign mark_found = found_q;
  assign byte_vld   = bvld_q;
  assign byte_data  = bdat_q;
endmodule

// File: rtl/amark_seq_chk.sv
module amark_seq_chk #(
  parameter int HOLD_CYC = 8000
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic smp_stb,
  input logic mark_found,
  input logic byte_vld,
  input logic crc_vld,
  input logic crc_good
);
  localparam int RW = $clog2(HOLD_CYC + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (byte_vld) run_q <= '0;
    else if (crc_vld)  run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R2: a mark is only reported after a sampled strobe
  assert_mark_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mark_found |-> $past(smp_stb));

  // R4: bytes only complete on a sampled strobe while enabled
  assert_byte_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(smp_stb) && $past(en)));

  // R9: disable quiets every output on the next cycle
  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!byte_vld && !mark_found && !crc_vld));

  // R8: status window opens right after the last byte
  assert_status_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_vld) |-> $past(byte_vld));

  // R8: status held steady inside the window
  assert_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_vld && $past(crc_vld) && !$past(byte_vld)) |-> $stable(crc_good));

  // R8: window never longer than the hold length
  assert_window_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(HOLD_CYC));
endmodule

bind amark_seq amark_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .smp_stb    (smp_stb),
  .mark_found (mark_found),
  .byte_vld   (byte_vld),
  .crc_vld    (crc_vld),
  .crc_good   (crc_good)
);

// File: tb/amark_seq_test.sv
module amark_seq_test;
  localparam int HOLD = 64;
  localparam int NV   = 6;
  // {want[31:24], sent[23:16], len[15:8], seed[7:4], corrupt[3], clkzero[2]}
  localparam logic [31:0] VEC [NV] = '{
    {8'hFB, 8'hFB, 8'd4,  4'd1, 1'b0, 1'b0, 2'b00},
    {8'hF8, 8'hF8, 8'd1,  4'd2, 1'b0, 1'b1, 2'b00},
    {8'hFB, 8'hF8, 8'd3,  4'd3, 1'b0, 1'b0, 2'b00},
    {8'hFE, 8'hFE, 8'd0,  4'd4, 1'b0, 1'b0, 2'b00},
    {8'hFB, 8'hFB, 8'd5,  4'd5, 1'b1, 1'b0, 2'b00},
    {8'hFB, 8'hFB, 8'd12, 4'd6, 1'b0, 1'b0, 2'b00}
  };

  logic clk = 1'b0;
  logic rst_n, en, stb, sbit;
  logic [7:0] mtype, flen;
  logic mark_found, byte_vld, crc_vld, crc_good;
  logic [7:0] byte_data;

  always #2 clk = ~clk;

  amark_seq #(.FLD_W(8), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_stb(stb), .smp_bit(sbit),
    .mark_type(mtype), .fld_len(flen), .mark_found(mark_found),
    .byte_vld(byte_vld), .byte_data(byte_data), .crc_vld(crc_vld),
    .crc_good(crc_good)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] rx [0:63];
  int rx_n, mk_n, cv_n, hi_n;
  logic cg, cv_prev;
  logic [7:0] fb [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        if (rx_n < 64) rx[rx_n] = byte_data;
        rx_n++;
      end
      if (mark_found) mk_n++;
      if (crc_vld) hi_n++;
      if (crc_vld && !cv_prev) begin
        cv_n++;
        cg = crc_good;
      end
      cv_prev = crc_vld;
    end
  end

  task automatic clr_mon();
    @(posedge clk);
    rx_n = 0; mk_n = 0; cv_n = 0; hi_n = 0; cg = 1'b0;
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic f;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      f = r[15] ^ b[k];
      r = {r[14:0], 1'b0};
      if (f) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic send_smp(input logic b);
    @(negedge clk);
    sbit = b; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_half(input logic [7:0] cb, input logic [7:0] db);
    for (int i = 7; i >= 0; i--) begin
      send_smp(cb[i]);
      send_smp(db[i]);
    end
  endtask

  task automatic lead_in();
    for (int i = 0; i < 12; i++) send_half(8'hFF, 8'h00);
  endtask

  task automatic tail();
    for (int i = 0; i < 3; i++) send_half(8'hFF, 8'h00);
  endtask

  task automatic make_field(input int n, input int seed, input logic [7:0] mk,
                            input bit corrupt);
    logic [15:0] c;
    c = crc_upd(16'hFFFF, mk);
    for (int i = 0; i < n; i++) begin
      fb[i] = 8'((seed * 29 + i * 47) ^ 8'h3C);
      c = crc_upd(c, fb[i]);
    end
    fb[n]   = c[15:8] ^ (corrupt ? 8'h01 : 8'h00);
    fb[n+1] = c[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; stb = 1'b0; sbit = 1'b0;
    mtype = 8'hFB; flen = 8'd0;
    rx_n = 0; mk_n = 0; cv_n = 0; hi_n = 0; cg = 1'b0; cv_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mark_found && !byte_vld && !crc_vld && !crc_good, "R1 reset outputs",
        {mark_found, byte_vld, crc_vld, crc_good}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] want, sent;
      int n, seed;
      bit corrupt, czero, match;
      want = VEC[v][31:24]; sent = VEC[v][23:16]; n = int'(VEC[v][15:8]);
      seed = int'(VEC[v][7:4]); corrupt = VEC[v][3]; czero = VEC[v][2];
      match = (want == sent);
      mtype = want; flen = 8'(n);
      make_field(n, seed, sent, corrupt);
      clr_mon();
      lead_in();
      send_half(8'hC7, 8'hF5);
      send_half(8'hC7, sent);
      for (int i = 0; i < n + 2; i++) send_half(czero ? 8'h00 : 8'hFF, fb[i]);
      tail();
      // R2 / R3: mark detection
      chk(mk_n == int'(match), match ? "R2 mark found" : "R3 mark mismatch",
          mk_n, int'(match));
      // R5 / R3: byte count
      chk(rx_n == (match ? n + 2 : 0), match ? "R5 field length" : "R3 no bytes",
          rx_n, match ? n + 2 : 0);
      if (match) begin
        for (int i = 0; i < n + 2; i++)
          chk(rx[i] == fb[i], czero ? "R4 clock samples ignored" : "R4 byte data",
              rx[i], fb[i]);
        chk(cv_n == 1, "R8 status once", cv_n, 1);
        chk(cg == !corrupt, corrupt ? "R7 crc error" : "R6 crc good", cg, !corrupt);
        chk(hi_n == HOLD, "R8 hold length", hi_n, HOLD);
      end else begin
        chk(cv_n == 0, "R3 no status", cv_n, 0);
      end
    end

    // R9: enable dropped mid-field
    mtype = 8'hFB; flen = 8'd6;
    make_field(6, 7, 8'hFB, 1'b0);
    clr_mon();
    lead_in();
    send_half(8'hC7, 8'hF5);
    send_half(8'hC7, 8'hFB);
    send_half(8'hFF, fb[0]);
    send_half(8'hFF, fb[1]);
    @(negedge clk);
    en = 1'b0;
    send_smp(1'b1);
    @(negedge clk);
    chk(!byte_vld && !mark_found && !crc_vld, "R9 quiet while disabled",
        {byte_vld, mark_found, crc_vld}, 0);
    en = 1'b1;
    for (int i = 2; i < 8; i++) send_half(8'hFF, fb[i]);
    tail();
    chk(mk_n == 1, "R9 mark before drop", mk_n, 1);
    chk(rx_n == 2, "R9 no bytes after drop", rx_n, 2);
    chk(cv_n == 0, "R9 no status after drop", cv_n, 0);

    // R9 / R3: search resumes and finds a fresh field
    make_field(2, 9, 8'hFB, 1'b0);
    flen = 8'd2;
    clr_mon();
    lead_in();
    send_half(8'hC7, 8'hF5);
    send_half(8'hC7, 8'hFB);
    for (int i = 0; i < 4; i++) send_half(8'hFF, fb[i]);
    tail();
    chk(mk_n == 1 && rx_n == 4, "R9 search resumes", rx_n, 4);
    chk(cv_n == 1 && cg == 1'b1, "R6 crc good after resume", {cv_n[3:0], cg}, 5'h03);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule